// File: doc/BRIEF.md
# Sound Synthesizer Interval Timer Pair

This block holds the two interval timers of an FM sound generator, together with their sticky overflow flags, a busy indicator and the automatic key trigger for the third channel's four operators. A strobe arrives once per output sample period and drives both timers. Timer A is a 10-bit up-counter that steps on every strobe. Timer B is an 8-bit up-counter that steps only on one strobe in sixteen. Each counter climbs to all-ones and then reloads from a value written by software, so the value written sets the period.

Writes come in as a strobe with a 2-bit register select and a data byte. The status byte reports both flags and a busy bit that stays high for a fixed number of clocks after every write. When the channel-3 mode field selects automatic keying, each timer A overflow sends a one-cycle key-on request to the operators that are not held on. A key-off request for those same operators follows on the next timer A increment. It also follows at once if software leaves the mode while the keying is active.

Top module: `fmt_timer_pair`

## Requirements
- R1: After reset, status reads 0x00, no key request is pulsed and both counters sit at all-ones.
- R2: Register select 0 writes timer A load bits 9..2 and select 1 writes load bits 1..0 (data bits 1..0). While running, timer A increments on each strobe and on the strobe where it is at 1023 reloads the load value, so a load of L overflows every 1024-L strobes.
- R3: Register select 2 writes the 8-bit timer B load. A 4-bit prescaler counts every strobe from reset whether or not B runs. Timer B steps only on strobes where the prescaler reads 0, and at 255 it reloads.
- R4: Select 3 is control: bit0 runs A, bit1 runs B, bit2 and bit3 enable flags A and B, bit4 and bit5 clear flags A and B, and bits 7..6 are the channel-3 mode, where 10b selects automatic keying.
- R5: A control write that turns a stopped timer on forces its counter to all-ones, and the first overflow after that raises no flag.
- R6: Any other overflow with its flag enable set sets status bit 0 (A) or bit 1 (B). The flag holds until a control write with the matching clear bit.
- R7: Status bit 7 is 1 for exactly 32 clocks, starting from the second rising edge after a write is sampled. Status bits 6..2 read 0.
- R8: In automatic keying mode, a timer A overflow while keying is inactive pulses key-on for the operators whose ch3_key_held bit is 0 and makes the keying active.
- R9: While keying is active, the next timer A increment (not a reload) pulses key-off with the same operator mask and ends the keying.
- R10: A control write that leaves automatic keying mode while keying is active pulses key-off with the stored mask after that edge.
- R11: A write and a strobe in the same clock act write-first: the strobe sees the new control and load values, and a flag clear in the same clock as an overflow leaves the flag set.
- R12: A stopped timer does not count or raise a flag, and a running timer with its flag enable at 0 never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-period strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 A high, 1 A low, 2 B, 3 control |
| wr_data | input | 8 | Write data |
| ch3_key_held | input | 4 | Channel-3 operators already keyed on by software |
| status | output | 8 | {busy, 5'b0, flag B, flag A} |
| csm_kon | output | 4 | One-cycle key-on request mask |
| csm_koff | output | 4 | One-cycle key-off request mask |

## Verification
Timer A is run with loads just under 1023, so that the suppressed first overflow, the period and a clear that falls in the same clock as an overflow each show up within a few strobes. Timer B is stepped one strobe at a time across 33 strobes, which separates a prescaler that steps on count 0 from one off by a strobe. Automatic keying is tried with a held mask that is not symmetric, so an inverted or stale mask in key-on or key-off is visible, and both exits from active keying are exercised. Random writes and strobes, with most loads near the top, then mix mode changes, re-enables and clears in the same clock against a reference model.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef enum logic [1:0] {
        SEL_A_HI = 2'd0,
        SEL_A_LO = 2'd1,
        SEL_B    = 2'd2,
        SEL_CTRL = 2'd3
    } fmt_sel_e;

    localparam int CB_RUN_A = 0;
    localparam int CB_RUN_B = 1;
    localparam int CB_FEN_A = 2;
    localparam int CB_FEN_B = 3;
    localparam int CB_CLR_A = 4;
    localparam int CB_CLR_B = 5;
    localparam int CB_MODE  = 6;
    localparam logic [1:0] MODE_AUTO_KEY = 2'b10;
endpackage

// File: rtl/fmt_interval.sv
module fmt_interval #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         run,
    input  logic         run_rise,
    input  logic         flag_en,
    input  logic         flag_clr,
    input  logic [W-1:0] load,
    output logic         flag,
    output logic         inc,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         loading;
        logic         flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        inc  = 1'b0;
        ovf  = 1'b0;
        if (run_rise) begin
            st_d.cnt     = TOP;
            st_d.loading = 1'b1;
        end
        if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        if (adv && run) begin
            if (st_d.cnt != TOP) begin
                inc      = 1'b1;
                st_d.cnt = st_d.cnt + 1'b1;
            end else begin
                ovf      = 1'b1;
                st_d.cnt = load;
                if (st_d.loading) begin
                    st_d.loading = 1'b0;
                end else if (flag_en) begin
                    st_d.flag = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: TOP, loading: 1'b0, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/fmt_busy.sv
module fmt_busy #(
    parameter int CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(CYCLES);

    typedef struct packed {
        logic          pend;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = wr;
        if (st_q.pend) begin
            st_d.cnt = RELOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);
endmodule

// File: rtl/fmt_autokey.sv
module fmt_autokey #(
    parameter int OPS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           a_inc,
    input  logic           a_ovf,
    input  logic           mode_on,
    input  logic           leave,
    input  logic [OPS-1:0] held,
    output logic [OPS-1:0] kon,
    output logic [OPS-1:0] koff
);
    typedef struct packed {
        logic           active;
        logic [OPS-1:0] mask;
        logic [OPS-1:0] kon;
        logic [OPS-1:0] koff;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kon  = '0;
        st_d.koff = '0;
        if (st_q.active && (leave || a_inc)) begin
            st_d.koff   = st_q.mask;
            st_d.active = 1'b0;
        end else if (a_ovf && !st_q.active && mode_on) begin
            st_d.mask   = ~held;
            st_d.kon    = ~held;
            st_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kon  = st_q.kon;
    assign koff = st_q.koff;
endmodule

// File: rtl/fmt_timer_pair.sv
module fmt_timer_pair #(
    parameter int A_W         = 10,
    parameter int B_W         = 8,
    parameter int B_PRE_W     = 4,
    parameter int BUSY_CYCLES = 32,
    parameter int OPS         = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,
    input  logic [7:0]     wr_data,
    input  logic [OPS-1:0] ch3_key_held,
    output logic [7:0]     status,
    output logic [OPS-1:0] csm_kon,
    output logic [OPS-1:0] csm_koff
);
    import fmt_pkg::*;

    localparam int A_LO_W = 2;
    localparam int A_HI_W = A_W - A_LO_W;
    localparam int PAD_W  = 8 - 3;

    typedef struct packed {
        logic [A_HI_W-1:0]  a_hi;
        logic [A_LO_W-1:0]  a_lo;
        logic [B_W-1:0]     b_ld;
        logic               run_a;
        logic               run_b;
        logic               fen_a;
        logic               fen_b;
        logic [1:0]         mode;
        logic [B_PRE_W-1:0] pre;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, rise_a, rise_b, clr_a, clr_b, leave, adv_b;
    logic  flag_a, flag_b, a_inc, a_ovf, b_inc, b_ovf, busy;

    always_comb begin
        r_d     = r_q;
        wr_ctrl = wr_en && (fmt_sel_e'(wr_sel) == SEL_CTRL);
        if (wr_en) begin
            case (fmt_sel_e'(wr_sel))
                SEL_A_HI: r_d.a_hi = wr_data[A_HI_W-1:0];
                SEL_A_LO: r_d.a_lo = wr_data[A_LO_W-1:0];
                SEL_B:    r_d.b_ld = wr_data[B_W-1:0];
                default: begin
                    r_d.run_a = wr_data[CB_RUN_A];
                    r_d.run_b = wr_data[CB_RUN_B];
                    r_d.fen_a = wr_data[CB_FEN_A];
                    r_d.fen_b = wr_data[CB_FEN_B];
                    r_d.mode  = wr_data[CB_MODE+1:CB_MODE];
                end
            endcase
        end
        if (tick) begin
            r_d.pre = r_q.pre + 1'b1;
        end
        rise_a = wr_ctrl && wr_data[CB_RUN_A] && !r_q.run_a;
        rise_b = wr_ctrl && wr_data[CB_RUN_B] && !r_q.run_b;
        clr_a  = wr_ctrl && wr_data[CB_CLR_A];
        clr_b  = wr_ctrl && wr_data[CB_CLR_B];
        leave  = wr_ctrl && (r_q.mode == MODE_AUTO_KEY)
                 && (wr_data[CB_MODE+1:CB_MODE] != MODE_AUTO_KEY);
        adv_b  = tick && (r_q.pre == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    fmt_interval #(.W(A_W)) u_tmr_a (
        .clk(clk), .rst_n(rst_n), .adv(tick), .run(r_d.run_a),
        .run_rise(rise_a), .flag_en(r_d.fen_a), .flag_clr(clr_a),
        .load({r_d.a_hi, r_d.a_lo}), .flag(flag_a), .inc(a_inc), .ovf(a_ovf)
    );

    fmt_interval #(.W(B_W)) u_tmr_b (
        .clk(clk), .rst_n(rst_n), .adv(adv_b), .run(r_d.run_b),
        .run_rise(rise_b), .flag_en(r_d.fen_b), .flag_clr(clr_b),
        .load(r_d.b_ld), .flag(flag_b), .inc(b_inc), .ovf(b_ovf)
    );

    fmt_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .busy(busy)
    );

    fmt_autokey #(.OPS(OPS)) u_key (
        .clk(clk), .rst_n(rst_n), .a_inc(a_inc), .a_ovf(a_ovf),
        .mode_on(r_d.mode == MODE_AUTO_KEY), .leave(leave),
        .held(ch3_key_held), .kon(csm_kon), .koff(csm_koff)
    );

    assign status = {busy, {PAD_W{1'b0}}, flag_b, flag_a};
endmodule

// File: rtl/fmt_timer_pair_chk.sv
module fmt_timer_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [3:0] ch3_key_held,
    input logic [7:0] status,
    input logic [3:0] csm_kon,
    input logic [3:0] csm_koff,
    input logic       b_inc,
    input logic       b_ovf
);
    AST_KEY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !((csm_kon != 4'd0) && (csm_koff != 4'd0))); // R8

    AST_KON_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (csm_kon != 4'd0) |=> (csm_kon == 4'd0)); // R8

    AST_KON_SKIPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (csm_kon != 4'd0) |-> ((csm_kon & $past(ch3_key_held)) == 4'd0)); // R8

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ##2 status[7]); // R7

    AST_FLAG_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(wr_en && wr_sel == 2'd3 && wr_data[4])) |=> status[0]); // R6

    AST_FLAG_A_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(tick)); // R6

    AST_B_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (b_inc || b_ovf) |-> tick); // R3
endmodule

bind fmt_timer_pair fmt_timer_pair_chk u_chk (.*);

// File: tb/sim_fmt_timer_pair.sv
`timescale 1ns/1ps
module sim_fmt_timer_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_tick = 1'b0, i_wr = 1'b0;
    logic [1:0] i_sel = 2'd0;
    logic [7:0] i_data = 8'd0;
    logic [3:0] i_held = 4'd0;
    logic [7:0] status;
    logic [3:0] kon, koff;

    int n_chk = 0, n_bad = 0;

    // reference model state
    int   m_a, m_b, m_pre, m_ahi, m_alo, m_bld, m_bcnt;
    bit   m_run_a, m_run_b, m_fen_a, m_fen_b, m_lda, m_ldb, m_fa, m_fb, m_act, m_pend;
    bit [1:0] m_mode;
    bit [3:0] m_mask, m_kon, m_koff;

    always #10 clk = ~clk;

    fmt_timer_pair u0 (
        .clk(clk), .rst_n(rst_n), .tick(i_tick), .wr_en(i_wr), .wr_sel(i_sel),
        .wr_data(i_data), .ch3_key_held(i_held), .status(status),
        .csm_kon(kon), .csm_koff(koff)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_a = 1023; m_b = 255; m_pre = 0; m_ahi = 0; m_alo = 0; m_bld = 0; m_bcnt = 0;
        m_run_a = 0; m_run_b = 0; m_fen_a = 0; m_fen_b = 0; m_lda = 0; m_ldb = 0;
        m_fa = 0; m_fb = 0; m_act = 0; m_pend = 0; m_mode = 0; m_mask = 0; m_kon = 0; m_koff = 0;
    endtask

    task automatic model_step();
        bit wc, ra, rb, ca, cb, lv, advb, ainc, aovf;
        wc   = i_wr && (i_sel == 2'd3);
        ra   = wc && i_data[0] && !m_run_a;
        rb   = wc && i_data[1] && !m_run_b;
        ca   = wc && i_data[4];
        cb   = wc && i_data[5];
        lv   = wc && (m_mode == 2'b10) && (i_data[7:6] != 2'b10);
        advb = i_tick && (m_pre == 0);
        if (m_pend) m_bcnt = 32; else if (m_bcnt > 0) m_bcnt--;
        m_pend = i_wr;
        if (i_wr) begin
            case (i_sel)
                2'd0: m_ahi = i_data;
                2'd1: m_alo = i_data[1:0];
                2'd2: m_bld = i_data;
                default: begin
                    m_run_a = i_data[0]; m_run_b = i_data[1];
                    m_fen_a = i_data[2]; m_fen_b = i_data[3]; m_mode = i_data[7:6];
                end
            endcase
        end
        if (i_tick) m_pre = (m_pre + 1) % 16;
        if (ra) begin m_a = 1023; m_lda = 1; end
        if (rb) begin m_b = 255; m_ldb = 1; end
        if (ca) m_fa = 0;
        if (cb) m_fb = 0;
        ainc = 0; aovf = 0;
        if (i_tick && m_run_a) begin
            if (m_a != 1023) begin m_a++; ainc = 1; end
            else begin
                aovf = 1; m_a = m_ahi * 4 + m_alo;
                if (m_lda) m_lda = 0; else if (m_fen_a) m_fa = 1;
            end
        end
        if (advb && m_run_b) begin
            if (m_b != 255) m_b++;
            else begin
                m_b = m_bld;
                if (m_ldb) m_ldb = 0; else if (m_fen_b) m_fb = 1;
            end
        end
        m_kon = 0; m_koff = 0;
        if (m_act && (lv || ainc)) begin
            m_koff = m_mask; m_act = 0;
        end else if (aovf && !m_act && m_mode == 2'b10) begin
            m_mask = ~i_held; m_kon = m_mask; m_act = 1;
        end
    endtask

    task automatic compare();
        chk("R6 flag A", status[0], m_fa);
        chk("R6/R3 flag B", status[1], m_fb);
        chk("R7 busy", status[7], m_bcnt != 0);
        chk("R7 pad bits", status[6:2], 0);
        chk("R8 key-on", kon, m_kon);
        chk("R9/R10 key-off", koff, m_koff);
    endtask

    task automatic cyc(bit t, bit w, logic [1:0] s, logic [7:0] dat);
        i_tick = t; i_wr = w; i_sel = s; i_data = dat;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; i_tick = 0; i_wr = 0; i_sel = 0; i_data = 0;
        @(negedge clk);
        @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        chk("R1 status after reset", status, 8'h00);
        chk("R1 kon after reset", kon, 4'h0);
        chk("R1 koff after reset", koff, 4'h0);
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int busy_n;
        // R7: busy window length
        do_reset();
        cyc(0, 1, 2'd0, 8'h12);
        busy_n = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(0, 0, 0, 0);
            if (status[7]) busy_n++;
        end
        chk("R7 busy length", busy_n, 32);

        // R5 / R2: first overflow suppressed, then period 1024-1020
        do_reset();
        cyc(0, 1, 2'd0, 8'hFF);
        cyc(0, 1, 2'd1, 8'h00);
        cyc(0, 1, 2'd3, 8'h05);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0);
        chk("R5 no flag on first overflow", status[0], 0);
        cyc(1, 0, 0, 0);
        chk("R2 flag after reload period", status[0], 1);
        cyc(0, 1, 2'd3, 8'h15);
        chk("R6 flag cleared", status[0], 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
        chk("R2 no flag before period end", status[0], 0);
        cyc(1, 0, 0, 0);
        chk("R6 flag on periodic overflow", status[0], 1);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
        cyc(1, 1, 2'd3, 8'h15);
        chk("R11 clear with overflow keeps flag", status[0], 1);
        // R12: stopped timer, and running without flag enable
        cyc(0, 1, 2'd3, 8'h14);
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0);
        chk("R12 stopped timer no flag", status[0], 0);
        cyc(0, 1, 2'd3, 8'h01);
        for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0);
        chk("R12 flag enable off no flag", status[0], 0);

        // R3 / R4: timer B prescale by 16
        do_reset();
        cyc(0, 1, 2'd2, 8'hFE);
        cyc(0, 1, 2'd3, 8'h0A);
        for (int i = 0; i < 32; i++) cyc(1, 0, 0, 0);
        chk("R3/R4 B flag not yet", status[1], 0);
        cyc(1, 0, 0, 0);
        chk("R3/R4 B flag after 33 strobes", status[1], 1);

        // R8 / R9 / R10: automatic keying
        do_reset();
        i_held = 4'b0101;
        cyc(0, 1, 2'd0, 8'hFF);
        cyc(0, 1, 2'd1, 8'h02);
        cyc(0, 1, 2'd3, 8'h81);
        cyc(1, 0, 0, 0);
        chk("R8 key-on mask", kon, 4'b1010);
        cyc(1, 0, 0, 0);
        chk("R9 key-off on increment", koff, 4'b1010);
        chk("R9 no key-on with key-off", kon, 4'b0000);
        cyc(1, 0, 0, 0);
        chk("R8 key-on again", kon, 4'b1010);
        cyc(0, 1, 2'd3, 8'h01);
        chk("R10 key-off on mode exit", koff, 4'b1010);
        cyc(0, 0, 0, 0);
        chk("R10 key-off is one cycle", koff, 4'b0000);

        // random mix against the model
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            bit t, w;
            logic [1:0] s;
            logic [7:0] dv;
            if (i % 64 == 0) i_held = 4'($urandom);
            t  = ($urandom % 2) == 0;
            w  = ($urandom % 8) == 0;
            s  = 2'($urandom);
            dv = 8'($urandom);
            if (s == 2'd0 || s == 2'd2) dv = 8'hF8 | 8'($urandom % 8);
            if (s == 2'd3 && ($urandom % 2) == 0) dv = {2'b10, dv[5:0]};
            cyc(t, w, s, dv);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial void'($urandom(32'd7919));
endmodule